// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block prepares the second operand of a data-path instruction. It takes a data word, a shift kind, a shift amount, a flag that tells whether the amount was read from a register or encoded in the instruction, and the current carry flag. It returns the shifted word together with the carry that the shift produces. Zero and oversized amounts carry special meanings, and these depend on the shift kind and on the amount source.

A second mode builds a constant from a byte and a small rotate field. The byte is zero-extended and rotated right by twice the field value. The shift is computed combinationally and captured in an output register. A single-cycle valid strobe marks each new result. Operand fetch and the arithmetic that consumes the result are outside the block.

Top module: `opsh_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted input, `out_valid`, `result` and `carry_out` are all 0.
- R2: An input accepted with `in_valid` high at a rising edge appears on `result`/`carry_out` after that edge, with `out_valid` high for exactly that one cycle. While `in_valid` is low, `out_valid` is 0 and `result`/`carry_out` keep their last values.
- R3: `shift_kind` codes are 0 = logical left, 1 = logical right, 2 = arithmetic right (sign fill), 3 = rotate right. For an effective amount n in 1..31 the result is `src_val` moved n places in that manner.
- R4: For an effective amount n in 1..31, `carry_out` is `src_val[32-n]` for logical left and `src_val[n-1]` for the other three kinds.
- R5: With effective amount 0, logical left and arithmetic right return `src_val` unchanged, and `carry_out` equals `carry_in`.
- R6: With effective amount 0, logical right returns `src_val` unchanged, and `carry_out` equals `src_val[31]`.
- R7: With effective amount 0, rotate right depends on the source. With `amt_from_reg`=1 it returns `src_val` and `carry_in`. With `amt_from_reg`=0 it returns `{carry_in, src_val[31:1]}` with `carry_out` = `src_val[0]`.
- R8: With `amt_from_reg`=0 only `shift_amt[4:0]` is used. With `amt_from_reg`=1 all 8 bits of `shift_amt` are used.
- R9: A logical shift by 32 or more returns 0. The carry is `src_val[0]` for logical left by exactly 32 and `src_val[31]` for logical right by exactly 32. For amounts above 32 the carry is 0.
- R10: An arithmetic right shift by 32 or more returns 32 copies of `src_val[31]`, and `carry_out` = `src_val[31]`.
- R11: A rotate by a register amount uses the amount modulo 32. A nonzero multiple of 32 returns `src_val` unchanged with `carry_out` = `src_val[31]`.
- R12: With `imm_mode`=1 the result is `imm_byte`, zero-extended to 32 bits and rotated right by 2×`imm_rot`. `carry_out` equals `carry_in`, and `src_val`, `shift_kind`, `shift_amt` and `amt_from_reg` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are accepted this cycle |
| imm_mode | input | 1 | 1 selects the byte/rotate constant path |
| src_val | input | 32 | Word to be shifted |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 8 | Shift amount (low 5 bits only when encoded) |
| amt_from_reg | input | 1 | 1 = amount came from a register |
| carry_in | input | 1 | Current carry flag |
| imm_byte | input | 8 | Constant byte for immediate mode |
| imm_rot | input | 4 | Rotate field; rotation is twice this value |
| out_valid | output | 1 | One-cycle strobe for a new result |
| result | output | 32 | Registered shifted value |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The directed tests aim at the amount-zero cases of every kind under both amount sources. A design that treated all of them alike would show a wrong carry on logical right, or would skip the one-bit rotate through carry. Amounts of 32, 33 and 255 from a register cover the edge cases of the large-shift rules. A shifter that wrapped the amount modulo 32 would return a non-zero word or a stale carry there. Encoded amounts with upper bits set catch a design that does not mask to five bits. Rotates by 32 and 64 catch a design that loses the bit-31 carry when the rotated value looks unchanged. In immediate mode every other shift input is set to a conflicting value, to expose any leak from the shift path.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

endpackage

// File: rtl/opsh_core.sv
module opsh_core
   import opsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] val,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              from_reg,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   localparam int SH_W = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

   initial begin
      cfg_amt_width_chk : assert (AMT_W > SH_W)
         else $fatal(1, "AMT_W must exceed log2(DATA_W)");
      cfg_pow2_chk : assert ((1 << SH_W) == DATA_W)
         else $fatal(1, "DATA_W must be a power of two");
   end

   logic [AMT_W-1:0]         n_eff;
   logic [SH_W-1:0]          k;
   logic                     n_zero;
   logic                     n_full;
   logic                     n_over;
   logic [DATA_W:0]          lsl_w;
   logic [DATA_W:0]          lsr_w;
   logic signed [DATA_W:0]   asr_src;
   logic signed [DATA_W:0]   asr_w;
   logic [2*DATA_W-1:0]      rot_w;

   // encoded amounts carry only log2(DATA_W) bits; register amounts use all
   always_comb begin
      n_eff  = from_reg ? amt : AMT_W'(amt[SH_W-1:0]);
      k      = n_eff[SH_W-1:0];
      n_zero = (n_eff == '0);
      n_full = (n_eff == FULL_AMT);
      n_over = (n_eff >= FULL_AMT);
   end

   // one extra bit on the shifted side catches the last bit pushed out
   always_comb begin
      lsl_w   = {1'b0, val} << k;
      lsr_w   = {val, 1'b0} >> k;
      asr_src = {val, 1'b0};
      asr_w   = asr_src >>> k;
      rot_w   = {val, val} >> k;
   end

   always_comb begin
      res  = val;
      cout = cin;
      unique case (kind)
         SK_LSL: begin
            if (n_zero) begin
               res  = val;
               cout = cin;
            end else if (n_over) begin
               res  = '0;
               cout = n_full ? val[0] : 1'b0;
            end else begin
               res  = lsl_w[DATA_W-1:0];
               cout = lsl_w[DATA_W];
            end
         end
         SK_LSR: begin
            if (n_zero) begin
               res  = val;
               cout = val[DATA_W-1];
            end else if (n_over) begin
               res  = '0;
               cout = n_full ? val[DATA_W-1] : 1'b0;
            end else begin
               res  = lsr_w[DATA_W:1];
               cout = lsr_w[0];
            end
         end
         SK_ASR: begin
            if (n_zero) begin
               res  = val;
               cout = cin;
            end else if (n_over) begin
               res  = {DATA_W{val[DATA_W-1]}};
               cout = val[DATA_W-1];
            end else begin
               res  = asr_w[DATA_W:1];
               cout = asr_w[0];
            end
         end
         SK_ROR: begin
            if (n_zero) begin
               if (from_reg) begin
                  res  = val;
                  cout = cin;
               end else begin
                  res  = {cin, val[DATA_W-1:1]};
                  cout = val[0];
               end
            end else begin
               res  = rot_w[DATA_W-1:0];
               cout = rot_w[DATA_W-1];
            end
         end
         default: begin
            res  = val;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/opsh_imm_expand.sv
module opsh_imm_expand #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm_byte,
   input  logic [ROT_W-1:0]  rot_fld,
   output logic [DATA_W-1:0] value
);

   localparam int SH_W  = $clog2(DATA_W);
   localparam int DBL_W = 2 * DATA_W;

   initial begin
      cfg_imm_fit_chk : assert (IMM_W <= DATA_W)
         else $fatal(1, "IMM_W must not exceed DATA_W");
      cfg_rot_fit_chk : assert (ROT_W + 1 <= SH_W)
         else $fatal(1, "twice the rotate field must stay below DATA_W");
   end

   logic [DATA_W-1:0] ext;
   logic [DBL_W-1:0]  dbl;
   logic [SH_W-1:0]   rot_amt;

   assign ext     = DATA_W'(imm_byte);
   assign dbl     = {ext, ext};
   assign rot_amt = SH_W'({rot_fld, 1'b0});

   // each output bit picks its source from the doubled word
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic [SH_W:0] src_idx;
      assign src_idx  = (SH_W+1)'(i) + (SH_W+1)'(rot_amt);
      assign value[i] = dbl[src_idx];
   end

endmodule

// File: rtl/opsh_out_reg.sv
module opsh_out_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_res,
   input  logic              d_carry,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_res,
   output logic              q_carry
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_res   <= '0;
         q_carry <= 1'b0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) begin
            q_res   <= d_res;
            q_carry <= d_carry;
         end
      end
   end

   // R2
   strobe_follow_chk : assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |=> q_valid);

   // R2
   idle_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |=> (!q_valid && $stable(q_res) && $stable(q_carry)));

endmodule

// File: rtl/opsh_unit.sv
module opsh_unit
   import opsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              imm_mode,
   input  logic [DATA_W-1:0] src_val,
   input  logic [1:0]        shift_kind,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              amt_from_reg,
   input  logic              carry_in,
   input  logic [IMM_W-1:0]  imm_byte,
   input  logic [ROT_W-1:0]  imm_rot,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);

   logic [DATA_W-1:0] sh_res;
   logic              sh_carry;
   logic [DATA_W-1:0] imm_val;
   logic [DATA_W-1:0] sel_res;
   logic              sel_carry;

   opsh_core #(
      .DATA_W (DATA_W),
      .AMT_W  (AMT_W)
   ) u_core (
      .val      (src_val),
      .kind     (shift_kind_e'(shift_kind)),
      .amt      (shift_amt),
      .from_reg (amt_from_reg),
      .cin      (carry_in),
      .res      (sh_res),
      .cout     (sh_carry)
   );

   opsh_imm_expand #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .ROT_W  (ROT_W)
   ) u_imm (
      .imm_byte (imm_byte),
      .rot_fld  (imm_rot),
      .value    (imm_val)
   );

   always_comb begin
      sel_res   = imm_mode ? imm_val : sh_res;
      sel_carry = imm_mode ? carry_in : sh_carry;
   end

   opsh_out_reg #(
      .DATA_W (DATA_W)
   ) u_oreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_res   (sel_res),
      .d_carry (sel_carry),
      .q_valid (out_valid),
      .q_res   (result),
      .q_carry (carry_out)
   );

   // R5
   lsl_zero_pass_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !imm_mode && shift_kind == 2'd0 && shift_amt == '0)
      |=> (result == $past(src_val) && carry_out == $past(carry_in)));

   // R7
   ror_through_carry_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !imm_mode && shift_kind == 2'd3 && !amt_from_reg && shift_amt == '0)
      |=> (result == {$past(carry_in), $past(src_val[DATA_W-1:1])}
           && carry_out == $past(src_val[0])));

   // R9
   logical_flush_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !imm_mode && !shift_kind[1] && amt_from_reg
       && shift_amt > AMT_W'(DATA_W))
      |=> (result == '0 && !carry_out));

   // R10
   asr_sign_fill_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !imm_mode && shift_kind == 2'd2 && amt_from_reg
       && shift_amt >= AMT_W'(DATA_W))
      |=> (result == {DATA_W{$past(src_val[DATA_W-1])}}
           && carry_out == $past(src_val[DATA_W-1])));

   // R12
   imm_plain_byte_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && imm_mode && imm_rot == '0)
      |=> (result == DATA_W'($past(imm_byte)) && carry_out == $past(carry_in)));

endmodule

// File: tb/tb_opsh_unit.sv
module tb_opsh_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        imm_mode = 1'b0;
   logic [31:0] src_val = '0;
   logic [1:0]  shift_kind = '0;
   logic [7:0]  shift_amt = '0;
   logic        amt_from_reg = 1'b0;
   logic        carry_in = 1'b0;
   logic [7:0]  imm_byte = '0;
   logic [3:0]  imm_rot = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        carry_out;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opsh_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_mode(imm_mode),
      .src_val(src_val), .shift_kind(shift_kind), .shift_amt(shift_amt),
      .amt_from_reg(amt_from_reg), .carry_in(carry_in), .imm_byte(imm_byte),
      .imm_rot(imm_rot), .out_valid(out_valid), .result(result),
      .carry_out(carry_out)
   );

   // independent bitwise model of the requirements
   function automatic void ref_shift(input logic [31:0] v, input int kind,
                                     input int amt, input bit from_reg,
                                     input bit cin, output logic [31:0] r,
                                     output bit c);
      int n;
      n = from_reg ? (amt & 255) : (amt & 31);
      r = v;
      c = cin;
      if (n == 0) begin
         if (kind == 1) c = v[31];
         if (kind == 3 && !from_reg) begin
            r = {cin, v[31:1]};
            c = v[0];
         end
      end else begin
         for (int i = 0; i < 32; i++) begin
            case (kind)
               0: r[i] = (i >= n) ? v[i-n] : 1'b0;
               1: r[i] = (i + n < 32) ? v[i+n] : 1'b0;
               2: r[i] = (i + n < 32) ? v[i+n] : v[31];
               default: r[i] = v[(i+n)%32];
            endcase
         end
         case (kind)
            0: c = (n <= 32) ? v[32-n] : 1'b0;
            1: c = (n <= 32) ? v[n-1] : 1'b0;
            2: c = (n <= 32) ? v[n-1] : v[31];
            default: c = v[(n-1)%32];
         endcase
      end
   endfunction

   function automatic logic [31:0] ref_imm(input logic [7:0] b, input int rot);
      logic [31:0] e;
      logic [31:0] r;
      e = {24'd0, b};
      for (int i = 0; i < 32; i++) r[i] = e[(i + 2*rot) % 32];
      return r;
   endfunction

   task automatic check(input string tag, input bit ok, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_out(input string tag, input logic [31:0] er, input bit ec);
      check(tag, out_valid === 1'b1, "out_valid", {31'd0, out_valid}, 32'd1);
      check(tag, result === er, "result", result, er);
      check(tag, carry_out === ec, "carry_out", {31'd0, carry_out}, {31'd0, ec});
   endtask

   task automatic drive(input bit imm, input logic [31:0] v, input int kind,
                        input int amt, input bit fr, input bit cin,
                        input logic [7:0] ib, input int ir);
      @(negedge clk);
      in_valid     = 1'b1;
      imm_mode     = imm;
      src_val      = v;
      shift_kind   = 2'(kind);
      shift_amt    = 8'(amt);
      amt_from_reg = fr;
      carry_in     = cin;
      imm_byte     = ib;
      imm_rot      = 4'(ir);
      @(negedge clk);
      in_valid     = 1'b0;
   endtask

   task automatic run_shift(input string tag, input logic [31:0] v, input int kind,
                            input int amt, input bit fr, input bit cin);
      logic [31:0] er;
      bit ec;
      ref_shift(v, kind, amt, fr, cin, er, ec);
      drive(1'b0, v, kind, amt, fr, cin, 8'h5A, 7);
      check_out(tag, er, ec);
   endtask

   task automatic t_reset();
      // R1: outputs clear during and right after reset
      check("R1", out_valid === 1'b0, "out_valid", {31'd0, out_valid}, 32'd0);
      check("R1", result === 32'd0, "result", result, 32'd0);
      check("R1", carry_out === 1'b0, "carry_out", {31'd0, carry_out}, 32'd0);
   endtask

   task automatic t_basic();
      // R3 and R4: moderate amounts, each kind
      run_shift("R3", 32'h8000_0001, 0, 4, 1'b0, 1'b0);
      run_shift("R3", 32'hF000_000F, 1, 3, 1'b1, 1'b0);
      run_shift("R3", 32'h8000_0010, 2, 5, 1'b0, 1'b0);
      run_shift("R3", 32'h0000_00F1, 3, 8, 1'b1, 1'b0);
      run_shift("R4", 32'h4000_0000, 0, 1, 1'b0, 1'b0);
      run_shift("R4", 32'h0000_0001, 1, 1, 1'b0, 1'b0);
      run_shift("R4", 32'h8000_0000, 2, 31, 1'b1, 1'b0);
      run_shift("R4", 32'h0000_0001, 0, 31, 1'b1, 1'b0);
   endtask

   task automatic t_zero();
      run_shift("R5", 32'h1234_5678, 0, 0, 1'b0, 1'b1);
      run_shift("R5", 32'h8765_4321, 2, 0, 1'b1, 1'b1);
      run_shift("R5", 32'h8765_4321, 0, 0, 1'b1, 1'b0);
      run_shift("R6", 32'h8000_0000, 1, 0, 1'b0, 1'b0);
      run_shift("R6", 32'h7FFF_FFFF, 1, 0, 1'b1, 1'b1);
      run_shift("R7", 32'h0000_0003, 3, 0, 1'b0, 1'b1);
      run_shift("R7", 32'h0000_0002, 3, 0, 1'b0, 1'b0);
      run_shift("R7", 32'hABCD_EF01, 3, 0, 1'b1, 1'b1);
   endtask

   task automatic t_imm_source();
      // R8: upper amount bits dropped when encoded
      run_shift("R8", 32'h0000_0F0F, 0, 37, 1'b0, 1'b0);
      run_shift("R8", 32'h8000_0001, 3, 32, 1'b0, 1'b1);
      run_shift("R8", 32'hC000_0000, 2, 224, 1'b0, 1'b1);
      run_shift("R8", 32'hC000_0000, 2, 225, 1'b1, 1'b0);
   endtask

   task automatic t_large();
      run_shift("R9", 32'h0000_0001, 0, 32, 1'b1, 1'b0);
      run_shift("R9", 32'h8000_0000, 1, 32, 1'b1, 1'b0);
      run_shift("R9", 32'hFFFF_FFFF, 0, 33, 1'b1, 1'b1);
      run_shift("R9", 32'hFFFF_FFFF, 1, 255, 1'b1, 1'b1);
      run_shift("R10", 32'h8000_0000, 2, 32, 1'b1, 1'b0);
      run_shift("R10", 32'h8000_0000, 2, 200, 1'b1, 1'b0);
      run_shift("R10", 32'h7FFF_FFFF, 2, 40, 1'b1, 1'b1);
   endtask

   task automatic t_ror_mult();
      run_shift("R11", 32'h8000_1234, 3, 32, 1'b1, 1'b0);
      run_shift("R11", 32'h0000_1234, 3, 64, 1'b1, 1'b1);
      run_shift("R11", 32'h0000_00F0, 3, 36, 1'b1, 1'b0);
      run_shift("R11", 32'h0000_0080, 3, 232, 1'b1, 1'b0);
   endtask

   task automatic t_imm_mode();
      // R12: conflicting shift inputs must not matter
      for (int r = 0; r < 16; r += 5) begin
         drive(1'b1, 32'hFFFF_FFFF, 1, 3, 1'b1, 1'b1, 8'hC3, r);
         check_out("R12", ref_imm(8'hC3, r), 1'b1);
      end
      drive(1'b1, 32'h1234_5678, 0, 0, 1'b0, 1'b0, 8'h81, 1);
      check_out("R12", 32'h4000_0020, 1'b0);
      drive(1'b1, 32'h0, 3, 0, 1'b0, 1'b1, 8'hFF, 0);
      check_out("R12", 32'h0000_00FF, 1'b1);
   endtask

   task automatic t_hold();
      logic [31:0] er;
      bit ec;
      ref_shift(32'hDEAD_BEEF, 0, 4, 1'b1, 1'b0, er, ec);
      drive(1'b0, 32'hDEAD_BEEF, 0, 4, 1'b1, 1'b0, 8'h00, 0);
      check_out("R2", er, ec);
      @(negedge clk);
      src_val = 32'h1111_1111;
      shift_kind = 2'd1;
      carry_in = 1'b1;
      imm_mode = 1'b1;
      @(negedge clk);
      // R2: no new strobe and no output change without in_valid
      check("R2", out_valid === 1'b0, "out_valid idle", {31'd0, out_valid}, 32'd0);
      check("R2", result === er, "result held", result, er);
      check("R2", carry_out === ec, "carry held", {31'd0, carry_out}, {31'd0, ec});
   endtask

   task automatic t_sweep();
      // R4 and R3: every kind, both sources, amounts up to 40
      for (int kind = 0; kind < 4; kind++) begin
         for (int a = 0; a <= 40; a += 3) begin
            run_shift("R4", 32'hA5C3_0F96, kind, a, 1'b1, a[0]);
            run_shift("R3", 32'h5A3C_F069, kind, a, 1'b0, ~a[0]);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_zero();
      t_imm_source();
      t_large();
      t_ror_mult();
      t_imm_mode();
      t_hold();
      t_sweep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule